// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This block turns a logical address from a processor into a physical address. It looks up one entry in a page table that sits in memory. A logical address has two parts. The upper bits name a page and the lower bits give a word offset inside that page. The unit reads the entry for the page from an address formed as table base plus page number. It checks the entry and then returns either the frame number joined to the unchanged offset, or a fault code.

Software programs two settings: the table base and the table length in entries. A page number at or beyond the length is refused before any memory traffic. After a legal access the unit records use in the entry. It sets the referenced flag on every access and the modified flag on a write. It writes the updated entry back to memory only when a flag actually changes, and this write finishes before the response appears. Only one request is in flight at a time.

Top module: `pxl_page_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req` are 0, and base and length are 0, so any request then gets a bounds fault.
- R2: A request that raises no fault responds with code 0 and a physical address equal to {entry frame, request offset}.
- R3: A page number greater than or equal to the length setting responds with code 1 and physical address 0, and makes no memory access.
- R4: An entry whose bit 0 (present) is 0 responds with code 2 and physical address 0, and the entry in memory is left as it was.
- R5: A write to an entry whose bit 1 (write permission) is 0 responds with code 3 and leaves the entry unchanged. A read of such an entry succeeds.
- R6: After any successful access, bit 3 (referenced) of the entry in memory is 1. The frame field (bits above bit 4), bit 2 (cache enable) and the other flags keep their values.
- R7: After a successful write, bit 4 (modified) of the entry is 1. A read leaves bit 4 as it was.
- R8: The entry is written back exactly once when bit 3 or bit 4 changes, and never otherwise. The write-back completes in the cycle before `rsp_valid` rises.
- R9: `req_ready` is low from the cycle after acceptance until the response has been given. `rsp_valid` is a single-cycle pulse.
- R10: An in-bounds request issues exactly one read, at memory address (base + page number) modulo the memory address range.
- R11: A new base or length value applies to every request accepted after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_we | input | 1 | Load the table base |
| cfg_base_wdata | input | MEM_AW | New table base (entry address) |
| cfg_len_we | input | 1 | Load the table length |
| cfg_len_wdata | input | PAGE_W+1 | New table length in entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_laddr | input | PAGE_W+OFF_W | Logical address {page, offset} |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address {frame, offset}; 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 bounds, 2 not present, 3 protection |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 for an entry write-back, 0 for a read |
| mem_addr | output | MEM_AW | Entry address |
| mem_wdata | output | FRAME_W+5 | Updated entry |
| mem_rdata | input | FRAME_W+5 | Entry read data, valid the cycle after a read strobe |

## Verification
The assertions assume that the memory returns read data exactly one cycle after a read strobe and holds it until the next strobe. They also assume that nothing but this unit changes the table during a request. The bench memory is a single-port registered array that only the unit touches once the table has been loaded. The bench changes base and length only while the unit is idle. It drives a request only when it sees `req_ready` high, so no request is offered during a response.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_BOUNDS = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_PROT   = 2'd3
  } fault_e;

  localparam int PTE_VALID = 0;
  localparam int PTE_PROT  = 1;
  localparam int PTE_CACHE = 2;
  localparam int PTE_REF   = 3;
  localparam int PTE_DIRTY = 4;
  localparam int PTE_FLAGS = 5;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WT   = 3'd2,
    ST_WB   = 3'd3,
    ST_DONE = 3'd4
  } state_e;
endpackage

// File: rtl/pxl_addr_split.sv
module pxl_addr_split #(
  parameter int OFF_W  = 2,
  parameter int PAGE_W = 4,
  parameter int MEM_AW = 6
) (
  input  logic [PAGE_W+OFF_W-1:0] laddr,
  input  logic [PAGE_W:0]         len,
  input  logic [MEM_AW-1:0]       base,
  output logic [OFF_W-1:0]        offset,
  output logic                    in_bounds,
  output logic [MEM_AW-1:0]       pte_addr
);
  localparam int PAD_W = MEM_AW - PAGE_W;

  logic [PAGE_W-1:0] page;
  logic [MEM_AW-1:0] page_ext;

  assign page      = laddr[PAGE_W+OFF_W-1:OFF_W];
  assign offset    = laddr[OFF_W-1:0];
  assign in_bounds = {1'b0, page} < len;
  assign page_ext  = {{PAD_W{1'b0}}, page};
  assign pte_addr  = base + page_ext;
endmodule

// File: rtl/pxl_pte_check.sv
module pxl_pte_check
  import pxl_pkg::*;
#(
  parameter int OFF_W   = 2,
  parameter int FRAME_W = 4
) (
  input  logic [FRAME_W+PTE_FLAGS-1:0] pte,
  input  logic                         is_write,
  input  logic [OFF_W-1:0]             offset,
  output fault_e                       fault,
  output logic [FRAME_W+OFF_W-1:0]     paddr,
  output logic [FRAME_W+PTE_FLAGS-1:0] new_pte,
  output logic                         need_wb
);
  logic [FRAME_W+PTE_FLAGS-1:0] set_mask;

  always_comb begin
    if (!pte[PTE_VALID])                fault = FLT_ABSENT;
    else if (is_write && !pte[PTE_PROT]) fault = FLT_PROT;
    else                                 fault = FLT_NONE;
  end

  always_comb begin
    set_mask            = '0;
    set_mask[PTE_REF]   = 1'b1;
    set_mask[PTE_DIRTY] = is_write;
  end

  assign paddr   = {pte[FRAME_W+PTE_FLAGS-1:PTE_FLAGS], offset};
  assign new_pte = pte | set_mask;
  assign need_wb = (fault == FLT_NONE) && (new_pte != pte);
endmodule

// File: rtl/pxl_page_xlate.sv
module pxl_page_xlate
  import pxl_pkg::*;
#(
  parameter int OFF_W   = 2,
  parameter int PAGE_W  = 4,
  parameter int FRAME_W = 4,
  parameter int MEM_AW  = 6,
  localparam int LA_W   = PAGE_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W,
  localparam int PTE_W  = FRAME_W + PTE_FLAGS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_base_we,
  input  logic [MEM_AW-1:0] cfg_base_wdata,
  input  logic              cfg_len_we,
  input  logic [PAGE_W:0]   cfg_len_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_laddr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [PTE_W-1:0]  mem_wdata,
  input  logic [PTE_W-1:0]  mem_rdata
);
  state_e             state;
  logic [MEM_AW-1:0]  base_q;
  logic [PAGE_W:0]    len_q;
  logic [OFF_W-1:0]   off_q;
  logic               wr_q;
  logic [PA_W-1:0]    paddr_q;

  logic [OFF_W-1:0]   req_off;
  logic               req_in_bounds;
  logic [MEM_AW-1:0]  req_pte_addr;
  fault_e             chk_fault;
  logic [PA_W-1:0]    chk_paddr;
  logic [PTE_W-1:0]   chk_new_pte;
  logic               chk_need_wb;

  pxl_addr_split #(.OFF_W(OFF_W), .PAGE_W(PAGE_W), .MEM_AW(MEM_AW)) split_i (
    .laddr    (req_laddr),
    .len      (len_q),
    .base     (base_q),
    .offset   (req_off),
    .in_bounds(req_in_bounds),
    .pte_addr (req_pte_addr)
  );

  pxl_pte_check #(.OFF_W(OFF_W), .FRAME_W(FRAME_W)) check_i (
    .pte     (mem_rdata),
    .is_write(wr_q),
    .offset  (off_q),
    .fault   (chk_fault),
    .paddr   (chk_paddr),
    .new_pte (chk_new_pte),
    .need_wb (chk_need_wb)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (cfg_base_we) base_q <= cfg_base_wdata;
      if (cfg_len_we)  len_q  <= cfg_len_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      off_q     <= '0;
      wr_q      <= 1'b0;
      paddr_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            off_q <= req_off;
            wr_q  <= req_write;
            if (req_in_bounds) begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= req_pte_addr;
              state    <= ST_RD;
            end else begin
              rsp_valid <= 1'b1;
              rsp_fault <= FLT_BOUNDS;
              rsp_paddr <= '0;
              state     <= ST_DONE;
            end
          end
        end
        ST_RD: begin
          mem_req <= 1'b0;
          state   <= ST_WT;
        end
        ST_WT: begin
          if (chk_fault != FLT_NONE) begin
            rsp_valid <= 1'b1;
            rsp_fault <= chk_fault;
            rsp_paddr <= '0;
            state     <= ST_DONE;
          end else if (chk_need_wb) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= chk_new_pte;
            paddr_q   <= chk_paddr;
            state     <= ST_WB;
          end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= FLT_NONE;
            rsp_paddr <= chk_paddr;
            state     <= ST_DONE;
          end
        end
        ST_WB: begin
          mem_req   <= 1'b0;
          mem_we    <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_fault <= FLT_NONE;
          rsp_paddr <= paddr_q;
          state     <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pxl_page_xlate_chk.sv
module pxl_page_xlate_chk #(
  parameter int OFF_W   = 2,
  parameter int PAGE_W  = 4,
  parameter int FRAME_W = 4,
  parameter int MEM_AW  = 6
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic [PAGE_W+OFF_W-1:0]     req_laddr,
  input logic [PAGE_W:0]             len_q,
  input logic                        rsp_valid,
  input logic [FRAME_W+OFF_W-1:0]    rsp_paddr,
  input logic [1:0]                  rsp_fault,
  input logic                        mem_req,
  input logic                        mem_we,
  input logic [FRAME_W+4:0]          mem_wdata
);
  logic over_len;
  assign over_len = {1'b0, req_laddr[PAGE_W+OFF_W-1:OFF_W]} >= len_q;

  AST_BOUNDS_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && over_len) |=> (!mem_req && rsp_valid && rsp_fault == 2'd1)); // R3
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0)); // R4
  AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[3]); // R6
  AST_WB_BEFORE_RSP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |=> (rsp_valid && rsp_fault == 2'd0 && !mem_req)); // R8
  AST_BUSY_DURING_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R9
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req); // R9
endmodule

bind pxl_page_xlate pxl_page_xlate_chk #(
  .OFF_W(OFF_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .MEM_AW(MEM_AW)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_laddr(req_laddr),
  .len_q    (len_q),
  .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_wdata(mem_wdata)
);

// File: tb/pxl_page_xlate_tb_top.sv
module pxl_page_xlate_tb_top;
  localparam int OFF_W = 2, PAGE_W = 4, FRAME_W = 4, MEM_AW = 6;
  localparam int PTE_W = FRAME_W + 5, DEPTH = 1 << MEM_AW;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_base_we = 0, cfg_len_we = 0;
  logic [MEM_AW-1:0] cfg_base_wdata = '0;
  logic [PAGE_W:0] cfg_len_wdata = '0;
  logic req_valid = 0, req_write = 0, req_ready;
  logic [PAGE_W+OFF_W-1:0] req_laddr = '0;
  logic rsp_valid, mem_req, mem_we;
  logic [FRAME_W+OFF_W-1:0] rsp_paddr;
  logic [1:0] rsp_fault;
  logic [MEM_AW-1:0] mem_addr;
  logic [PTE_W-1:0] mem_wdata, mem_rdata;

  logic [PTE_W-1:0] mem [DEPTH];
  logic [PTE_W-1:0] ref_tbl [DEPTH];
  logic ld_en = 0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [PTE_W-1:0] ld_data = '0;

  int n_chk = 0, n_fail = 0, rd_cnt = 0, wr_cnt = 0, cyc = 0;
  logic [MEM_AW-1:0] rd_addr = '0;
  int cur_base = 0, cur_len = 0;

  always #10 clk = ~clk;

  pxl_page_xlate #(.OFF_W(OFF_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .MEM_AW(MEM_AW)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_base_we(cfg_base_we), .cfg_base_wdata(cfg_base_wdata),
    .cfg_len_we(cfg_len_we), .cfg_len_wdata(cfg_len_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end
    if (mem_req && !mem_we) begin rd_cnt <= rd_cnt + 1; rd_addr <= mem_addr; end
    if (mem_req && mem_we) wr_cnt <= wr_cnt + 1;
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [PTE_W-1:0] init_pte(int a);
    logic [FRAME_W-1:0] fr = FRAME_W'((a * 7 + 3) % 16);
    logic v = (a % 5) != 2;
    logic p = (a % 3) != 0;
    logic c = a[0];
    logic r = a[2] & a[0];
    logic d = a[3] & a[1];
    return {fr, d, r, c, p, v};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic load_table();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      ld_en = 1; ld_addr = MEM_AW'(a); ld_data = init_pte(a);
      ref_tbl[a] = init_pte(a);
    end
    @(negedge clk) ld_en = 0;
  endtask

  task automatic set_cfg(int b, int l);
    @(negedge clk);
    cfg_base_we = 1; cfg_base_wdata = MEM_AW'(b);
    cfg_len_we = 1; cfg_len_wdata = (PAGE_W+1)'(l);
    @(negedge clk);
    cfg_base_we = 0; cfg_len_we = 0;
    cur_base = b; cur_len = l;
  endtask

  task automatic do_req(int pg, int off, bit w);
    int a, ef, epa, ewr, erd;
    logic [PTE_W-1:0] e, ne;
    int r0, w0, waitc;
    a = (cur_base + pg) % DEPTH;
    ef = 0; epa = 0; ewr = 0; erd = 1;
    if (pg >= cur_len) begin ef = 1; erd = 0; end
    else begin
      e = ref_tbl[a];
      if (!e[0]) ef = 2;
      else if (w && !e[1]) ef = 3;
      else begin
        epa = (int'(e[PTE_W-1:5]) << OFF_W) | off;
        ne = e | 9'b000001000 | (w ? 9'b000010000 : 9'b0);
        ewr = (ne != e) ? 1 : 0;
        ref_tbl[a] = ne;
      end
    end
    @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    req_valid = 1; req_write = w;
    req_laddr = {PAGE_W'(pg), OFF_W'(off)};
    @(negedge clk);
    req_valid = 0;
    if (!rsp_valid) chk("R9 busy after accept", req_ready, 0);
    waitc = 0;
    while (!rsp_valid && waitc < 20) begin @(negedge clk); waitc++; end
    chk("R9 response seen", rsp_valid, 1);
    chk("R9 ready low during response", req_ready, 0);
    chk($sformatf("R3 R4 R5 fault pg%0d w%0d", pg, w), rsp_fault, ef);
    chk($sformatf("R2 paddr pg%0d off%0d", pg, off), rsp_paddr, epa);
    chk("R3 R10 read count", rd_cnt - r0, erd);
    if (erd == 1) chk("R10 read address", rd_addr, a);
    chk("R8 write-back count", wr_cnt - w0, ewr);
    if (erd == 1) chk($sformatf("R4 R5 R6 R7 entry at %0d", a), mem[a], ref_tbl[a]);
    @(negedge clk);
    chk("R9 single-cycle response", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 no response after reset", rsp_valid, 0);
    chk("R1 no memory access after reset", mem_req, 0);
    load_table();
    do_req(0, 1, 0);   // R1: length is 0, bounds fault
    set_cfg(8, 12);    // R11
    for (int pass = 0; pass < 2; pass++)
      for (int pg = 0; pg < 16; pg++)
        for (int w = 0; w < 2; w++)
          do_req(pg, (pg + w + pass) % 4, w[0]);
    set_cfg(56, 16);   // R11: wraps past the top of memory
    for (int pg = 0; pg < 16; pg++)
      for (int w = 0; w < 2; w++)
        do_req(pg, (3 * pg + w) % 4, w[0]);
    set_cfg(0, 0);     // R11: length back to 0
    do_req(5, 2, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule